// File: doc/BRIEF.md
# Five-channel down-counting timer

A memory-mapped timer block with five independent down-counters whose width (16 or 32 bits) is chosen by a parameter. Software programs it through a plain write bus (write enable, byte address, 32-bit data). Reads are combinational from the same address. A shared clock stage makes the count ticks. Two 8-bit prescalers each serve a group of channels, and each channel has its own power-of-two divider after its group prescaler.

Each channel loads its counter from a count buffer under manual update. It then counts down on its ticks and raises an event on reaching zero. After the event it either reloads and keeps running or stops. Channels 0 to 3 also compare the counter against a compare buffer and drive a level output that can be inverted. Events latch into pending flags. Each channel has an interrupt line that is high while its flag and its enable are both set.

Top module: `tmr5_core`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0, and `pwm_o` is 4'b1111 because a zero counter is at or below a zero compare value.
- R2: Byte addresses are fixed. Prescaler config is at 0x00, divider config at 0x04 and control at 0x08. The count buffer of channel c is at 0x0C+12c, and the compare buffer of channels 0..3 is at 0x10+12c. The count observation of channels 0..3 is at 0x14+12c, channel 4's is at 0x40, and the interrupt register is at 0x44. Count and compare buffers keep only the low CNT_W bits of the write data and read back zero-extended.
- R3: Control uses one 4-bit group per channel: channel 0 is group 0 and channel c (1..4) is group c+1. Within a group, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is autoreload. Group 5 has autoreload at its bit 2 (control bit 22) and no invert. Group 1 and control bit 23 are not stored, so writing all ones reads back 0x7FFF0F.
- R4: While manual update is set, the channel counter takes the count buffer value every cycle. The value is visible in the observation register.
- R5: Prescaler bits [7:0] (P0) serve channels 0 and 1, and bits [15:8] (P1) serve channels 2 to 4. Divider bits [4c+3:4c] hold code k. Channel c ticks every (P+1)*2^(k+B) clock cycles, with B=1 for CNT_W=16 and B=0 for CNT_W=32. A running channel loaded with N raises events every (N+1) ticks.
- R6: With autoreload set, a channel reloads from its count buffer at the zero event and keeps running. With it clear, the channel stops at zero after one event and raises no more until a new manual update.
- R7: Interrupt register bits [4:0] are enables and bits [9:5] are pending flags. An event sets its flag. Writing 1 to a flag bit clears it, and an event in the same cycle wins. `irq_o[c]` is high exactly while enable c and flag c are both set.
- R8: For channels 0..3, `pwm_o[c]` is 1 while the counter is at or below the compare buffer, inverted by the invert bit.
- R9: With start and manual update both clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address for writes and reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 5 | Per-channel interrupt lines |
| pwm_o | output | 4 | Compare outputs of channels 0..3 |

## Verification
The assertions assume that the write strobe, address and data are known and stable across each clock edge. They also assume a write-1-clear of a pending flag is only judged in cycles without a competing event, and the clear property is guarded for exactly that case. The bench drives the bus on falling edges, one write per cycle. It reconfigures a channel only by first rewriting control, which stops the other channels. Tick periods are measured only between two events that follow a settled prescaler and divider setting.

// File: rtl/tmr5_pkg.sv
package tmr5_pkg;
  localparam int NCH  = 5;
  localparam int NCMP = 4;
  localparam logic [7:0] A_PRE = 8'h00;
  localparam logic [7:0] A_DIV = 8'h04;
  localparam logic [7:0] A_CTL = 8'h08;
  localparam logic [7:0] A_INT = 8'h44;
  localparam logic [23:0] CTL_MASK = 24'h7FFF0F;

  function automatic logic [7:0] a_buf(input int ch);
    return 8'(12 * ch + 12);
  endfunction
  function automatic logic [7:0] a_cmp(input int ch);
    return 8'(12 * ch + 16);
  endfunction
  function automatic logic [7:0] a_obs(input int ch);
    return (ch == 4) ? 8'h40 : 8'(12 * ch + 20);
  endfunction
  // control group of a channel: group 1 is skipped
  function automatic int ctl_grp(input int ch);
    return (ch == 0) ? 0 : ch + 1;
  endfunction
endpackage

// File: rtl/tmr5_clk.sv
module tmr5_clk #(
  parameter int DIV_BASE = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] pre_cfg_i,
  input  logic [19:0] div_cfg_i,
  output logic [4:0]  tick_o
);
  localparam int SEL_W  = 4;
  localparam int DCNT_W = (1 << SEL_W) - 1 + DIV_BASE;

  logic [1:0] pre_tick;

  for (genvar g = 0; g < 2; g++) begin : g_pre
    logic [7:0] cnt_q;
    logic [7:0] lim;
    assign lim         = pre_cfg_i[8*g +: 8];
    assign pre_tick[g] = (cnt_q >= lim);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (pre_tick[g]) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 8'd1;
    end
  end

  for (genvar c = 0; c < 5; c++) begin : g_div
    localparam int G = (c < 2) ? 0 : 1;
    logic [DCNT_W-1:0] dcnt_q;
    logic [4:0]        sh;
    logic [DCNT_W:0]   mask;
    assign sh        = 5'(div_cfg_i[4*c +: SEL_W]) + 5'(DIV_BASE);
    assign mask      = ((DCNT_W+1)'(1) << sh) - (DCNT_W+1)'(1);
    assign tick_o[c] = pre_tick[G] && ((dcnt_q & mask[DCNT_W-1:0]) == mask[DCNT_W-1:0]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          dcnt_q <= '0;
      else if (pre_tick[G]) dcnt_q <= dcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr5_chan.sv
module tmr5_chan #(
  parameter int CNT_W   = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             manual_i,
  input  logic             auto_i,
  input  logic             inv_i,
  input  logic [CNT_W-1:0] buf_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             run;

  assign run   = start_i && !done_q && !manual_i;
  assign evt_o = run && tick_i && (cnt_q == '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (manual_i) begin
      cnt_q  <= buf_i;
      done_q <= 1'b0;
    end else if (run && tick_i) begin
      if (cnt_q != '0)  cnt_q  <= cnt_q - 1'b1;
      else if (auto_i)  cnt_q  <= buf_i;
      else              done_q <= 1'b1;
    end
  end

  if (HAS_CMP) begin : g_cmp
    assign pwm_o = (cnt_q <= cmp_i) ^ inv_i;
  end else begin : g_nocmp
    logic unused_cmp;
    assign unused_cmp = ^{cmp_i, inv_i};
    assign pwm_o      = 1'b0;
  end

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    manual_i |=> cnt_q == $past(buf_i));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !manual_i) |=> $stable(cnt_q));
  p_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !manual_i && tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !auto_i) |=> cnt_q == '0);
  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && auto_i) |=> cnt_q == $past(buf_i));
endmodule

// File: rtl/tmr5_core.sv
module tmr5_core
  import tmr5_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [4:0]  irq_o,
  output logic [3:0]  pwm_o
);
  localparam int DIV_BASE = (CNT_W == 16) ? 1 : 0;

  logic [15:0] pre_q;
  logic [19:0] div_q;
  logic [23:0] ctl_q;
  logic [4:0]  ien_q, pend_q, evt, tick, pwm_all, clr;
  logic [NCH-1:0][CNT_W-1:0]  buf_q, cnt_w;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic        wr_int;

  assign wr_int = wr_en_i && (addr_i == A_INT);
  assign clr    = wr_int ? wdata_i[9:5] : 5'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0; div_q <= '0; ctl_q <= '0; ien_q <= '0; pend_q <= '0;
      buf_q <= '0; cmp_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | evt;  // event wins over clear
      if (wr_en_i) begin
        if (addr_i == A_PRE) pre_q <= wdata_i[15:0];
        if (addr_i == A_DIV) div_q <= wdata_i[19:0];
        if (addr_i == A_CTL) ctl_q <= wdata_i[23:0] & CTL_MASK;
        if (addr_i == A_INT) ien_q <= wdata_i[4:0];
        for (int c = 0; c < NCH; c++)
          if (addr_i == a_buf(c)) buf_q[c] <= wdata_i[CNT_W-1:0];
        for (int c = 0; c < NCMP; c++)
          if (addr_i == a_cmp(c)) cmp_q[c] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_PRE) rdata_o = {16'b0, pre_q};
    if (addr_i == A_DIV) rdata_o = {12'b0, div_q};
    if (addr_i == A_CTL) rdata_o = {8'b0, ctl_q};
    if (addr_i == A_INT) rdata_o = {22'b0, pend_q, ien_q};
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == a_buf(c)) rdata_o = 32'(buf_q[c]);
      if (addr_i == a_obs(c)) rdata_o = 32'(cnt_w[c]);
    end
    for (int c = 0; c < NCMP; c++)
      if (addr_i == a_cmp(c)) rdata_o = 32'(cmp_q[c]);
  end

  tmr5_clk #(.DIV_BASE(DIV_BASE)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .pre_cfg_i(pre_q), .div_cfg_i(div_q), .tick_o(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int G = ctl_grp(c);
    localparam bit HC = (c < NCMP);
    logic auto_b, inv_b;
    logic [CNT_W-1:0] cmp_b;
    if (HC) begin : g_c
      assign auto_b = ctl_q[4*G+3];
      assign inv_b  = ctl_q[4*G+2];
      assign cmp_b  = cmp_q[c];
    end else begin : g_n
      assign auto_b = ctl_q[4*G+2];
      assign inv_b  = 1'b0;
      assign cmp_b  = '0;
    end
    tmr5_chan #(.CNT_W(CNT_W), .HAS_CMP(HC)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick[c]),
      .start_i(ctl_q[4*G]), .manual_i(ctl_q[4*G+1]), .auto_i(auto_b), .inv_i(inv_b),
      .buf_i(buf_q[c]), .cmp_i(cmp_b), .cnt_o(cnt_w[c]), .evt_o(evt[c]), .pwm_o(pwm_all[c])
    );
  end

  assign irq_o = ien_q & pend_q;
  assign pwm_o = pwm_all[3:0];

  logic unused_pwm4;
  assign unused_pwm4 = pwm_all[4];

  p_pend_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != 5'b0) |=> (pend_q & $past(evt)) == $past(evt));
  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_int && evt == 5'b0) |=> (pend_q & $past(wdata_i[9:5])) == 5'b0);
  p_ctl_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_CTL |=> ctl_q[7:4] == 4'b0 && !ctl_q[23]);
endmodule

// File: tb/tmr5_core_tb.sv
module tmr5_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int B = 1;
  // {channel, prescaler, divider code, count buffer}
  localparam int NV = 5;
  localparam int VEC [NV][4] = '{
    '{0, 1, 0, 3}, '{1, 0, 2, 1}, '{2, 2, 1, 2}, '{3, 3, 0, 1}, '{4, 0, 0, 4}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [4:0] irq;
  logic [3:0] pwm;
  int cyc = 0, checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr5_core #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .pwm_o(pwm)
  );

  function automatic int grp(int ch); return (ch == 0) ? 0 : ch + 1; endfunction
  function automatic logic [31:0] b_st(int ch); return 32'(1) << (4*grp(ch)); endfunction
  function automatic logic [31:0] b_man(int ch); return 32'(1) << (4*grp(ch)+1); endfunction
  function automatic logic [31:0] b_ar(int ch);
    return (ch == 4) ? 32'(1) << 22 : 32'(1) << (4*grp(ch)+3);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); wr_en = 1'b0; addr = a; #1 d = rdata;
  endtask

  task automatic wait_rise(input int ch, output int t, output bit ok);
    logic prev = irq[ch];
    ok = 1'b0; t = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (irq[ch] && !prev) begin t = cyc; ok = 1'b1; return; end
      prev = irq[ch];
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int t1, t2;
    bit ok1, ok2;
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset state
    rd(8'h08, d); chk("R1 ctl", d, 0);
    rd(8'h44, d); chk("R1 int", d, 0);
    rd(8'h14, d); chk("R1 obs0", d, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pwm", 32'(pwm), 32'hF);

    // R2 truncation and address map
    wr(8'h0C, 32'h12345); rd(8'h0C, d); chk("R2 buf0 trunc", d, 32'h2345);
    wr(8'h10, 32'hABCDE); rd(8'h10, d); chk("R2 cmp0 trunc", d, 32'hBCDE);
    wr(8'h3C, 32'h77);    rd(8'h3C, d); chk("R2 buf4", d, 32'h77);

    // R3 control layout
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R3 ctl mask", d, 32'h7FFF0F);
    wr(8'h08, 0);

    // R4 manual update, R9 hold
    wr(8'h24, 32'h55); wr(8'h08, b_man(2)); wr(8'h08, 0);
    rd(8'h2C, d); chk("R4 obs2 load", d, 32'h55);
    wr(8'h40 - 8'h04, 32'h0); // channel 4 buffer is 0x3C: cleared
    wr(8'h00, 0); idle(20);
    rd(8'h2C, d); chk("R9 hold", d, 32'h55);

    // R6 one-shot on channel 3, R7 masking and clear
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h30, 3); wr(8'h44, 32'h3E0);
    wr(8'h08, b_man(3)); wr(8'h08, b_st(3));
    idle(40);
    rd(8'h44, d); chk("R6 oneshot pending", d, 32'h100);
    rd(8'h38, d); chk("R6 oneshot stop", d, 0);
    chk("R7 masked irq", 32'(irq[3]), 0);
    wr(8'h44, 32'h008); chk("R7 enabled irq", 32'(irq[3]), 1);
    wr(8'h44, 32'h108); chk("R7 w1c irq", 32'(irq[3]), 0);
    idle(40);
    rd(8'h44, d); chk("R6 no second event", d, 32'h008);

    // R8 compare output on channel 1
    wr(8'h08, 0); wr(8'h18, 5); wr(8'h1C, 5); wr(8'h08, b_man(1)); wr(8'h08, 0);
    chk("R8 cnt==cmp", 32'(pwm[1]), 1);
    wr(8'h1C, 4); chk("R8 cnt>cmp", 32'(pwm[1]), 0);
    wr(8'h08, 32'(1) << 10); chk("R8 invert", 32'(pwm[1]), 1);

    // R5/R6 tick timing with autoreload, table driven
    for (int v = 0; v < NV; v++) begin
      int ch = VEC[v][0], p = VEC[v][1], k = VEC[v][2], n = VEC[v][3];
      int exp_per = (n + 1) * (p + 1) * (1 << (k + B));
      wr(8'h08, 0);
      wr(8'h00, 32'((p << 8) | p));
      wr(8'h04, 32'(k) << (4*ch));
      wr(8'(12*ch + 12), 32'(n));
      wr(8'h44, 32'h3E0 | (32'(1) << ch));
      wr(8'h08, b_man(ch));
      wr(8'h08, b_st(ch) | b_ar(ch));
      wait_rise(ch, t1, ok1);
      wr(8'h44, (32'(1) << (ch + 5)) | (32'(1) << ch));
      wait_rise(ch, t2, ok2);
      chk($sformatf("R5 R6 period ch%0d", ch), (ok1 && ok2) ? 32'(t2 - t1) : 32'hFFFF_FFFF,
          32'(exp_per));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule